// File: doc/BRIEF.md
# Stereo PCM Serial Shifter

This block is the serial half of a 16-bit stereo PCM port that always acts as clock and frame master. A separate clock generator supplies two single-cycle strobes in the system clock domain. `launch_tick` marks the bit-clock edge on which outgoing data changes. `capture_tick` marks the opposite edge, on which incoming data is sampled. The generator also supplies `fsync`, which is high for exactly one bit period per frame. The bit clock is used inverted and the frame sync is not inverted, so the two strobes come from opposite edges.

On the transmit side the block takes one 16-bit word at a time from a FIFO front (`tx_data`/`tx_avail`/`tx_pop`). It shifts the left word and then the right word onto `sdo`, most significant bit first, and drives zero for the rest of the frame. On the receive side it assembles two words per frame from `sdi` and hands each one to a FIFO with a single-cycle `rx_push`, tagged by `rx_right`. Each direction has its own timing select. When the select is 0, the MSB sits in the same bit period as the sync pulse. When it is 1, the MSB follows one bit period later.

The two directions are enabled separately. `core_active` stays high while either one is enabled.

Each direction runs the same four-state machine:
- `LANE_OFF`: the direction is disabled.
- `LANE_SYNC`: enabled, waiting for a frame sync.
- `LANE_LEFT`: shifting the left word.
- `LANE_RIGHT`: shifting the right word.

Transitions:
- OFF to SYNC: on the cycle after the enable rises.
- Any enabled state to LEFT: on a tick that samples `fsync` high. A sync in the middle of a frame restarts the frame.
- LEFT to RIGHT: after the 16th bit of the left word.
- RIGHT to SYNC: after the 16th bit of the right word.
- Any state to OFF: whenever the enable is low. This takes precedence over everything else.

Top module: `pcm_serial_engine`

## Requirements
- R1: During and right after reset, `sdo`, `tx_pop`, `rx_push` and `core_active` are 0.
- R2: `core_active` equals `tx_en | rx_en` of the previous cycle. It stays high while either direction is enabled and clears only once both are off.
- R3: With `tx_late`=0, the MSB of the left word appears on `sdo` in the cycle after the `launch_tick` that samples `fsync` high.
- R4: With `tx_late`=1, the MSB of the left word appears on `sdo` after the first `launch_tick` following the one that sampled `fsync`.
- R5: Transmit bits go out MSB first: 16 bits of the left word, then immediately 16 bits of the right word. Every other bit period of the frame, and every bit period before the first sync, outputs 0.
- R6: `tx_pop` pulses for one cycle, in the `launch_tick` cycle that starts each word, only when `tx_avail` is 1. A word started while `tx_avail` is 0 is sent as 16 zeros and pops nothing.
- R7: With `rx_late`=0, the bit sampled at the `capture_tick` that sees `fsync` high is the MSB of the left word.
- R8: With `rx_late`=1, the MSB of the left word is the bit sampled at the next `capture_tick` after the one that saw `fsync`.
- R9: One cycle after the capture tick of a word's 16th bit, `rx_push` pulses for one cycle. At the same time `rx_word` holds the word and `rx_right` is 0 for left or 1 for right. The right word is taken from the 16 bits that follow the left word immediately.
- R10: While `tx_en` is 0, `sdo` is 0 from the next cycle and `tx_pop` stays 0. While `rx_en` is 0, no push occurs. After re-enabling, a direction waits for the next frame sync.
- R11: While transmit is enabled, `sdo` changes only in the cycle after a `launch_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_late | input | 1 | Transmit MSB one bit period after sync when 1 |
| rx_late | input | 1 | Receive MSB one bit period after sync when 1 |
| launch_tick | input | 1 | Strobe for the bit-clock edge that launches data |
| capture_tick | input | 1 | Strobe for the bit-clock edge that samples data |
| fsync | input | 1 | Frame sync, high for one bit period |
| tx_data | input | 16 | Word at the front of the transmit FIFO |
| tx_avail | input | 1 | Transmit FIFO holds a word |
| tx_pop | output | 1 | Consume the front transmit word |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| rx_word | output | 16 | Received word |
| rx_push | output | 1 | Write `rx_word` into the receive FIFO |
| rx_right | output | 1 | Received word belongs to the right channel |
| core_active | output | 1 | Port enabled (either direction on) |

## Verification
`tx_pop` is combinational and is due in the same cycle as its `launch_tick`. `sdo`, `rx_push`, `rx_word`, `rx_right` and `core_active` are registered and are due exactly one cycle after the strobe or enable change that causes them. The reference model counts bit periods from each sampled sync and derives the expected bit and push for every cycle. The bench drives inputs on the falling edge and compares every output shortly afterwards. The combinational output is compared against the expectation for the current cycle, and the registered outputs against the expectations computed in the previous cycle. Timing selects change only while both directions are off.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    typedef enum logic [1:0] {
        LANE_OFF   = 2'd0,
        LANE_SYNC  = 2'd1,
        LANE_LEFT  = 2'd2,
        LANE_RIGHT = 2'd3
    } lane_state_t;
endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              late,
    input  logic              tick,
    input  logic              fsync,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_avail,
    output logic              pop,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    lane_state_t       st_q, st_d, st_e;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_e;
    logic [WORD_W-1:0] sh_q, sh_d, cur;
    logic              sdo_q, sdo_d, step;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LANE_OFF;
            cnt_q <= '0;
            sh_q  <= '0;
            sdo_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sh_q  <= sh_d;
            sdo_q <= sdo_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        sh_d  = sh_q;
        sdo_d = sdo_q;
        pop   = 1'b0;
        st_e  = st_q;
        cnt_e = cnt_q;
        step  = 1'b0;
        cur   = sh_q;
        if (!en) begin
            st_d  = LANE_OFF;
            sdo_d = 1'b0;
        end else begin
            unique case (st_q)
                LANE_OFF: st_d = LANE_SYNC;
                LANE_SYNC, LANE_LEFT, LANE_RIGHT: begin
                    if (tick) begin
                        if (fsync) begin
                            st_e  = LANE_LEFT;
                            cnt_e = '0;
                            step  = !late;
                        end else begin
                            step = (st_q == LANE_LEFT) || (st_q == LANE_RIGHT);
                        end
                        st_d  = st_e;
                        cnt_d = cnt_e;
                        sdo_d = 1'b0;
                        if (step) begin
                            if (cnt_e == '0) begin
                                cur = word_avail ? word_in : '0;
                                pop = word_avail;
                            end
                            sdo_d = cur[WORD_W-1];
                            sh_d  = cur << 1;
                            if (cnt_e == LAST_BIT) begin
                                cnt_d = '0;
                                st_d  = (st_e == LANE_LEFT) ? LANE_RIGHT : LANE_SYNC;
                            end else begin
                                cnt_d = cnt_e + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
    import pcm_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              late,
    input  logic              tick,
    input  logic              fsync,
    input  logic              sdi,
    output logic [WORD_W-1:0] word_out,
    output logic              push,
    output logic              right_out
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    lane_state_t       st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] sh_q, sh_d, word_q, word_d, data;
    logic              push_q, push_d, right_q, right_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= LANE_OFF;
            cnt_q   <= '0;
            sh_q    <= '0;
            word_q  <= '0;
            push_q  <= 1'b0;
            right_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            word_q  <= word_d;
            push_q  <= push_d;
            right_q <= right_d;
        end
    end

    // next state and outputs
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        word_d  = word_q;
        right_d = right_q;
        push_d  = 1'b0;
        data    = {sh_q[WORD_W-2:0], sdi};
        if (!en) begin
            st_d = LANE_OFF;
        end else begin
            unique case (st_q)
                LANE_OFF: st_d = LANE_SYNC;
                LANE_SYNC, LANE_LEFT, LANE_RIGHT: begin
                    if (tick) begin
                        if (fsync) begin
                            st_d = LANE_LEFT;
                            if (late) begin
                                cnt_d = '0;
                            end else begin
                                sh_d  = data;
                                cnt_d = CNT_W'(1);
                            end
                        end else if (st_q != LANE_SYNC) begin
                            if (cnt_q == LAST_BIT) begin
                                push_d  = 1'b1;
                                word_d  = data;
                                right_d = (st_q == LANE_RIGHT);
                                cnt_d   = '0;
                                st_d    = (st_q == LANE_LEFT) ? LANE_RIGHT : LANE_SYNC;
                            end else begin
                                sh_d  = data;
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                    end
                end
            endcase
        end
    end

    assign word_out  = word_q;
    assign push      = push_q;
    assign right_out = right_q;
endmodule

// File: rtl/pcm_serial_engine.sv
module pcm_serial_engine #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_late,
    input  logic              rx_late,
    input  logic              launch_tick,
    input  logic              capture_tick,
    input  logic              fsync,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_avail,
    output logic              tx_pop,
    output logic              sdo,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_push,
    output logic              rx_right,
    output logic              core_active
);
    always_ff @(posedge clk) begin
        if (!rst_n) core_active <= 1'b0;
        else        core_active <= tx_en | rx_en;
    end

    pcm_tx_lane #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .late(tx_late),
        .tick(launch_tick), .fsync(fsync), .word_in(tx_data),
        .word_avail(tx_avail), .pop(tx_pop), .sdo(sdo)
    );

    pcm_rx_lane #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .late(rx_late),
        .tick(capture_tick), .fsync(fsync), .sdi(sdi),
        .word_out(rx_word), .push(rx_push), .right_out(rx_right)
    );
endmodule

// File: rtl/pcm_serial_engine_chk.sv
module pcm_serial_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rx_en,
    input logic launch_tick,
    input logic tx_avail,
    input logic tx_pop,
    input logic sdo,
    input logic rx_push,
    input logic core_active
);
    a_r2_core_follows_on: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> core_active);
    a_r2_core_follows_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |=> !core_active);
    a_r6_pop_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (tx_avail && launch_tick && tx_en));
    a_r9_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);
    a_r10_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !sdo);
    a_r10_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_push);
    a_r11_sdo_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !launch_tick) |=> $stable(sdo));
endmodule

bind pcm_serial_engine pcm_serial_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .launch_tick(launch_tick), .tx_avail(tx_avail), .tx_pop(tx_pop),
    .sdo(sdo), .rx_push(rx_push), .core_active(core_active)
);

// File: tb/test_pcm_serial_engine.sv
`timescale 1ns/1ps
module test_pcm_serial_engine;
    localparam int FRAME = 40;
    localparam int BIG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, rx_en = 0, tx_late = 0, rx_late = 0;
    logic launch_tick = 0, capture_tick = 0, fsync = 0, sdi = 0;
    logic [15:0] tx_data = '0;
    logic tx_avail = 0;
    logic tx_pop, sdo, rx_push, rx_right, core_active;
    logic [15:0] rx_word;

    always #10 clk = ~clk;

    pcm_serial_engine i_pcm_serial_engine (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .tx_late(tx_late), .rx_late(rx_late), .launch_tick(launch_tick),
        .capture_tick(capture_tick), .fsync(fsync), .tx_data(tx_data),
        .tx_avail(tx_avail), .tx_pop(tx_pop), .sdo(sdo), .sdi(sdi),
        .rx_word(rx_word), .rx_push(rx_push), .rx_right(rx_right),
        .core_active(core_active)
    );

    int checks = 0, errors = 0, gcnt = 0;
    bit done = 0;
    bit cfg_tx = 0, cfg_rx = 0, cfg_tl = 0, cfg_rl = 0;
    logic [15:0] txq[$];

    // reference model state
    int tp = BIG, rq = BIG;
    bit tx_prev = 0, rx_prev = 0;
    logic [15:0] cur = '0, acc = '0, e_word = '0;
    logic e_sdo = 0, e_push = 0, e_right = 0, e_core = 0;
    string sdo_tag = "R1", push_tag = "R1";

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, gcnt, act, exp);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            int ph, b, c;
            bit lt, ct, fs;
            logic e_pop;
            @(negedge clk);
            ph = gcnt % 4;
            lt = (ph == 0);
            ct = (ph == 2);
            fs = ((gcnt / 4) % FRAME) == 0;
            launch_tick = lt; capture_tick = ct; fsync = fs;
            tx_en = cfg_tx; rx_en = cfg_rx; tx_late = cfg_tl; rx_late = cfg_rl;
            if (lt) sdi = 1'($urandom_range(0, 1));
            tx_avail = (txq.size() > 0);
            tx_data  = (txq.size() > 0) ? txq[0] : 16'h0;
            #1;
            // registered outputs, due one cycle after their cause
            chk(sdo_tag, 16'(sdo), 16'(e_sdo));
            chk(push_tag, 16'(rx_push), 16'(e_push));
            if (e_push) begin
                chk(push_tag, rx_word, e_word);
                chk("R9", 16'(rx_right), 16'(e_right));
            end
            chk("R2", 16'(core_active), 16'(e_core));
            // transmit model
            e_pop = 0;
            sdo_tag = "R11";
            if (!tx_en) begin
                e_sdo = 0; tp = BIG; sdo_tag = "R10";
            end else if (tx_prev && lt) begin
                if (fs) tp = 0; else if (tp < BIG) tp++;
                b = tp - int'(tx_late);
                if (b == 0 || b == 16) begin
                    cur = tx_avail ? tx_data : 16'h0;
                    e_pop = tx_avail;
                end
                if (b >= 0 && b < 32) e_sdo = cur[15 - (b % 16)];
                else e_sdo = 0;
                sdo_tag = (b == 0) ? (tx_late ? "R4" : "R3") : "R5";
            end
            chk(tx_en ? "R6" : "R10", 16'(tx_pop), 16'(e_pop));
            if (e_pop) void'(txq.pop_front());
            // receive model
            e_push = 0;
            push_tag = rx_late ? "R8" : "R7";
            if (!rx_en) begin
                rq = BIG; push_tag = "R10";
            end else if (rx_prev && ct) begin
                if (fs) rq = 0; else if (rq < BIG) rq++;
                c = rq - int'(rx_late);
                if (c >= 0 && c < 32) begin
                    acc = {acc[14:0], sdi};
                    if (c == 15 || c == 31) begin
                        e_push = 1; e_word = acc; e_right = (c == 31);
                    end
                end
            end
            e_core = tx_en | rx_en;
            tx_prev = tx_en; rx_prev = rx_en;
            gcnt++;
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1", 16'(sdo), 16'h0);
        chk("R1", 16'(tx_pop), 16'h0);
        chk("R1", 16'(rx_push), 16'h0);
        chk("R1", 16'(core_active), 16'h0);
        rst_n = 1'b1;
        run(8);
        // early timing both ways, last frame underruns
        txq = '{16'hA5C3, 16'h8001, 16'h7FFE, 16'h1234, 16'hFFFF, 16'h0F0F};
        cfg_tx = 1; cfg_rx = 1;
        run(FRAME * 4 * 4 + 20);
        cfg_tx = 0;
        run(200);
        cfg_rx = 0;
        run(20);
        // late timing both ways
        cfg_tl = 1; cfg_rl = 1;
        txq = '{16'hC001, 16'h5AA5, 16'h8000, 16'h0001};
        cfg_tx = 1; cfg_rx = 1;
        run(FRAME * 4 * 3);
        cfg_tx = 0; cfg_rx = 0;
        run(10);
        // mixed timing, transmit dropped mid-word and resumed
        cfg_tl = 0; cfg_rl = 1;
        txq = '{16'h9669, 16'h3C3C, 16'hE00E, 16'h4242, 16'h1357, 16'hBEEF};
        cfg_tx = 1; cfg_rx = 1;
        run(250);
        cfg_tx = 0;
        run(37);
        cfg_tx = 1;
        run(FRAME * 4 * 3);
        cfg_tx = 0; cfg_rx = 0;
        run(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule